// File: doc/BRIEF.md
# Width-Limited In-Order Commit Controller

This block decides, once per cycle, which of the oldest entries of a reorder buffer leave it. The buffer presents a window of its `W` oldest entries for the thread chosen by an outside selector. Each entry is described by valid, ready, squashed, executed and fault flags, a class vector, a sequence number, a destination-write flag and the two following program-counter values. The block scans the window from oldest to youngest and gives each slot one action:

- `ACT_COMMIT`: retire it.
- `ACT_DROP`: discard a squashed entry.
- `ACT_HANDBACK`: return a serialized operation for execution.
- `ACT_TRAP`: raise a trap.
- `ACT_STOP`: end the scan.

A slot is examined only if every older slot was committed or dropped.

Each thread has a two-state machine, `TH_RUN` and `TH_TRAP`. Raising a trap moves the thread from `TH_RUN` to `TH_TRAP`. A `trap_clear` pulse moves it back to `TH_RUN`. While the thread is in `TH_TRAP`, nothing of that thread is retired. Per thread, the block also keeps:

- the committed PC and next PC;
- the youngest committed sequence number;
- a count of committed instructions.

It also keeps one count of cycles that used the full width. It reports an emptied buffer to earlier stages once all stores have settled. The rename-map write strobe marks committed entries that write a destination register. The map takes the register numbers from the same window entry.

The class vector is `W` groups of 7 bits. Within each group the bits are: 0 non-speculative, 1 store-conditional, 2 barrier, 3 load, 4 store, 5 nop, 6 instruction prefetch. Slot 0 is the oldest entry. Parameter `DELAY_SLOT` selects the PC update used when branches have a delay slot.

Top module: `commit_ctrl`

## Requirements
- R1: Slots are scanned from slot 0 upward. The scan ends at the first slot that is not valid or not ready. No slot acts when `sel_valid` is low. At most `W` entries commit per cycle, and `retire_mask` always has the form of a run of ones starting at bit 0.
- R2: A squashed entry reached by the scan is removed (its `retire_mask` bit is set) and the scan continues. It is not counted as a commit, so it neither fills the width nor stops a younger slot from being the first slot.
- R3: An unexecuted entry with class bit 0, 1 or 2 set is handed back only if no entry has committed earlier in the cycle and `stores_pending` is low. A hand-back pulses `nonspec_valid` with `nonspec_seq` set to the entry's sequence number and `nonspec_uncached` low; the entry stays in the buffer and the scan stops. In any other case the scan stops with no output.
- R4: An unexecuted entry with only class bit 3 set (a load) follows the same rule as R3, and `nonspec_uncached` is high during its hand-back.
- R5: An executed entry with its fault flag set raises `trap_req` only under the first-slot, no-pending-stores rule, and the scan stops. In the next cycle the thread shows `trap_pend` high and retires nothing. It stays that way until a `trap_clear` pulse for that thread.
- R6: In the cycle after at least one entry commits, the thread's `done_seq` holds the sequence number of the youngest committed entry. `pc_o` holds that entry's next PC, and `npc_o` holds that next PC plus `INST_B` (with `DELAY_SLOT` = 0).
- R7: `inst_cnt` of the thread grows by the number of committed entries that have neither class bit 5 nor class bit 6 set.
- R8: `bw_cnt` grows by one in every cycle in which exactly `W` entries commit.
- R9: `empty_rpt[t]` pulses only when all of the following hold: the thread's report is armed, `buf_empty[t]` is high, `stores_pending` is low, and no store of thread t commits in that cycle. The report is armed at reset and whenever the thread removes an entry, and it is disarmed by the pulse.
- R10: `map_we[i]` is high exactly when slot i commits and its `head_dst` bit is set.
- R11: After reset, for every thread: `pc_o` = 0, `npc_o` = `INST_B`, `done_seq` = 0, `inst_cnt` = 0, `trap_pend` = 0. `bw_cnt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | A thread is selected this cycle |
| sel_tid | input | TID_W | Selected thread |
| stores_pending | input | 1 | Stores are still waiting to write back |
| buf_empty | input | T | Per-thread buffer-empty flag |
| trap_clear | input | T | Per-thread trap completion pulse |
| head_valid | input | W | Window entry valid |
| head_ready | input | W | Window entry ready to commit |
| head_squashed | input | W | Window entry squashed |
| head_executed | input | W | Window entry executed |
| head_fault | input | W | Window entry faulted |
| head_dst | input | W | Window entry writes a destination register |
| head_cls | input | W*7 | Class bits per entry |
| head_seq | input | W*SEQ_W | Sequence number per entry |
| head_npc | input | W*PC_W | Next PC per entry |
| head_nnpc | input | W*PC_W | Next-next PC per entry |
| retire_mask | output | W | Entries removed this cycle |
| map_we | output | W | Committed rename-map write strobe |
| nonspec_valid | output | 1 | Hand-back of a serialized entry |
| nonspec_uncached | output | 1 | Hand-back is an uncached load |
| nonspec_seq | output | SEQ_W | Sequence number handed back |
| trap_req | output | 1 | Trap request for the selected thread |
| trap_pend | output | T | Thread is waiting for its trap |
| done_seq | output | T*SEQ_W | Youngest committed sequence number per thread |
| pc_o | output | T*PC_W | Committed PC per thread |
| npc_o | output | T*PC_W | Committed next PC per thread |
| inst_cnt | output | T*CNT_W | Committed instruction count per thread |
| bw_cnt | output | CNT_W | Full-width cycle count |
| empty_rpt | output | T | Buffer-empty report pulse per thread |

## Verification
The hardest situation to reach is the empty report being held back by a store that commits in the same cycle. From the ports, this needs three things at once: the thread's report must be armed by an earlier removal, the buffer-empty flag must be presented together with a committing store, and the report must then be seen to fire one cycle later. The stimulus first commits on the second thread to arm it. It then drives `buf_empty` high while a store commits, and then drives it high with an empty window.

A second hard case is the first-slot rule after a squash. Here a dropped entry at slot 0 must still let a serialized entry at slot 1 be handed back. This is produced by building that exact window.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CLS_W      = 7;
    localparam int CB_NONSPEC = 0;
    localparam int CB_STCOND  = 1;
    localparam int CB_BARRIER = 2;
    localparam int CB_LOAD    = 3;
    localparam int CB_STORE   = 4;
    localparam int CB_NOP     = 5;
    localparam int CB_IPREF   = 6;

    typedef enum logic [2:0] {
        ACT_STOP,
        ACT_COMMIT,
        ACT_DROP,
        ACT_HANDBACK,
        ACT_TRAP
    } slot_act_e;

    typedef enum logic {
        TH_RUN,
        TH_TRAP
    } thr_state_e;
endpackage

// File: rtl/cc_slot_scan.sv
module cc_slot_scan
    import cc_pkg::*;
#(
    parameter int W     = 4,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    localparam int NUM_W = $clog2(W + 1)
) (
    input  logic                 enable,
    input  logic                 stores_pending,
    input  logic [W-1:0]         head_valid,
    input  logic [W-1:0]         head_ready,
    input  logic [W-1:0]         head_squashed,
    input  logic [W-1:0]         head_executed,
    input  logic [W-1:0]         head_fault,
    input  logic [W*CLS_W-1:0]   head_cls,
    input  logic [W*SEQ_W-1:0]   head_seq,
    input  logic [W*PC_W-1:0]    head_npc,
    input  logic [W*PC_W-1:0]    head_nnpc,
    output logic [W-1:0]         retire_mask,
    output logic [W-1:0]         commit_mask,
    output logic [NUM_W-1:0]     commit_num,
    output logic [NUM_W-1:0]     counted_num,
    output logic                 handback,
    output logic                 handback_unc,
    output logic [SEQ_W-1:0]     handback_seq,
    output logic                 trap,
    output logic [SEQ_W-1:0]     last_seq,
    output logic [PC_W-1:0]      last_npc,
    output logic [PC_W-1:0]      last_nnpc,
    output logic                 store_commit
);

    function automatic slot_act_e decide(
        input logic             v,
        input logic             r,
        input logic             sq,
        input logic             ex,
        input logic             f,
        input logic [CLS_W-1:0] c,
        input logic             first
    );
        logic serial;
        serial = c[CB_NONSPEC] | c[CB_STCOND] | c[CB_BARRIER] | c[CB_LOAD];
        if (!v || !r)  return ACT_STOP;
        if (sq)        return ACT_DROP;
        if (!ex)       return (serial && first) ? ACT_HANDBACK : ACT_STOP;
        if (f)         return first ? ACT_TRAP : ACT_STOP;
        return ACT_COMMIT;
    endfunction

    logic [W-1:0]     alive;
    logic [NUM_W-1:0] cnt [0:W];
    slot_act_e        act [W];

    assign alive[0] = enable;
    assign cnt[0]   = '0;

    for (genvar g = 0; g < W; g++) begin : g_slot
        logic first_slot;
        assign first_slot = (cnt[g] == '0) && !stores_pending;
        assign act[g] = decide(head_valid[g], head_ready[g], head_squashed[g],
                               head_executed[g], head_fault[g],
                               head_cls[g*CLS_W +: CLS_W], first_slot);
        assign cnt[g+1] = cnt[g] + NUM_W'(alive[g] && act[g] == ACT_COMMIT);
        if (g < W - 1) begin : g_chain
            assign alive[g+1] = alive[g] &&
                                (act[g] == ACT_COMMIT || act[g] == ACT_DROP);
        end
    end

    assign commit_num = cnt[W];

    always_comb begin
        retire_mask  = '0;
        commit_mask  = '0;
        counted_num  = '0;
        handback     = 1'b0;
        handback_unc = 1'b0;
        handback_seq = '0;
        trap         = 1'b0;
        last_seq     = '0;
        last_npc     = '0;
        last_nnpc    = '0;
        store_commit = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (alive[i]) begin
                case (act[i])
                    ACT_DROP: retire_mask[i] = 1'b1;
                    ACT_COMMIT: begin
                        retire_mask[i] = 1'b1;
                        commit_mask[i] = 1'b1;
                        last_seq  = head_seq[i*SEQ_W +: SEQ_W];
                        last_npc  = head_npc[i*PC_W +: PC_W];
                        last_nnpc = head_nnpc[i*PC_W +: PC_W];
                        if (!head_cls[i*CLS_W + CB_NOP] && !head_cls[i*CLS_W + CB_IPREF])
                            counted_num = counted_num + NUM_W'(1);
                        if (head_cls[i*CLS_W + CB_STORE])
                            store_commit = 1'b1;
                    end
                    ACT_HANDBACK: begin
                        handback     = 1'b1;
                        handback_seq = head_seq[i*SEQ_W +: SEQ_W];
                        handback_unc = head_cls[i*CLS_W + CB_LOAD] &&
                                       !head_cls[i*CLS_W + CB_NONSPEC] &&
                                       !head_cls[i*CLS_W + CB_STCOND] &&
                                       !head_cls[i*CLS_W + CB_BARRIER];
                    end
                    ACT_TRAP: trap = 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cc_thread_ctx.sv
module cc_thread_ctx
    import cc_pkg::*;
#(
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 16,
    parameter int NUM_W      = 3,
    parameter int INST_B     = 4,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_en,
    input  logic             remove_en,
    input  logic [NUM_W-1:0] counted_num,
    input  logic [SEQ_W-1:0] last_seq,
    input  logic [PC_W-1:0]  last_npc,
    input  logic [PC_W-1:0]  last_nnpc,
    input  logic             trap_fire,
    input  logic             trap_clear,
    input  logic             buf_empty,
    input  logic             stores_pending,
    input  logic             store_commit,
    output logic             running,
    output logic             trap_pend,
    output logic [SEQ_W-1:0] done_seq,
    output logic [PC_W-1:0]  pc,
    output logic [PC_W-1:0]  npc,
    output logic [CNT_W-1:0] inst_cnt,
    output logic             empty_rpt
);

    thr_state_e      st_q, st_d;
    logic [PC_W-1:0] nnpc_q;
    logic            armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TH_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TH_RUN:  if (trap_fire)  st_d = TH_TRAP;
            TH_TRAP: if (trap_clear) st_d = TH_RUN;
            default: st_d = TH_RUN;
        endcase
    end

    assign running   = (st_q == TH_RUN);
    assign trap_pend = (st_q == TH_TRAP);
    assign empty_rpt = armed_q && buf_empty && !stores_pending && !store_commit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_seq <= '0;
            pc       <= '0;
            npc      <= PC_W'(INST_B);
            nnpc_q   <= PC_W'(2 * INST_B);
            inst_cnt <= '0;
            armed_q  <= 1'b1;
        end else begin
            armed_q <= remove_en || (armed_q && !empty_rpt);
            if (commit_en) begin
                done_seq <= last_seq;
                pc       <= last_npc;
                inst_cnt <= inst_cnt + CNT_W'(counted_num);
                if (DELAY_SLOT) begin
                    npc    <= last_nnpc;
                    nnpc_q <= last_nnpc + PC_W'(INST_B);
                end else begin
                    npc    <= last_npc + PC_W'(INST_B);
                    nnpc_q <= last_nnpc;
                end
            end
        end
    end

    a_r5_trap_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (running && trap_fire) |=> trap_pend);
    a_r5_no_commit_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pend |-> !commit_en);
    a_r6_done_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> done_seq == $past(last_seq));
    a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rpt |-> (!stores_pending && !store_commit && buf_empty));

endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
    import cc_pkg::*;
#(
    parameter int W          = 4,
    parameter int T          = 2,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 16,
    parameter int INST_B     = 4,
    parameter bit DELAY_SLOT = 1'b0,
    localparam int TID_W     = (T > 1) ? $clog2(T) : 1,
    localparam int NUM_W     = $clog2(W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_valid,
    input  logic [TID_W-1:0]     sel_tid,
    input  logic                 stores_pending,
    input  logic [T-1:0]         buf_empty,
    input  logic [T-1:0]         trap_clear,
    input  logic [W-1:0]         head_valid,
    input  logic [W-1:0]         head_ready,
    input  logic [W-1:0]         head_squashed,
    input  logic [W-1:0]         head_executed,
    input  logic [W-1:0]         head_fault,
    input  logic [W-1:0]         head_dst,
    input  logic [W*7-1:0]       head_cls,
    input  logic [W*SEQ_W-1:0]   head_seq,
    input  logic [W*PC_W-1:0]    head_npc,
    input  logic [W*PC_W-1:0]    head_nnpc,
    output logic [W-1:0]         retire_mask,
    output logic [W-1:0]         map_we,
    output logic                 nonspec_valid,
    output logic                 nonspec_uncached,
    output logic [SEQ_W-1:0]     nonspec_seq,
    output logic                 trap_req,
    output logic [T-1:0]         trap_pend,
    output logic [T*SEQ_W-1:0]   done_seq,
    output logic [T*PC_W-1:0]    pc_o,
    output logic [T*PC_W-1:0]    npc_o,
    output logic [T*CNT_W-1:0]   inst_cnt,
    output logic [CNT_W-1:0]     bw_cnt,
    output logic [T-1:0]         empty_rpt
);

    logic [T-1:0]     running;
    logic             scan_en;
    logic [W-1:0]     commit_mask;
    logic [NUM_W-1:0] commit_num, counted_num;
    logic [SEQ_W-1:0] last_seq;
    logic [PC_W-1:0]  last_npc, last_nnpc;
    logic             store_commit;

    assign scan_en = sel_valid && running[sel_tid];

    cc_slot_scan #(.W(W), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_scan (
        .enable        (scan_en),
        .stores_pending(stores_pending),
        .head_valid    (head_valid),
        .head_ready    (head_ready),
        .head_squashed (head_squashed),
        .head_executed (head_executed),
        .head_fault    (head_fault),
        .head_cls      (head_cls),
        .head_seq      (head_seq),
        .head_npc      (head_npc),
        .head_nnpc     (head_nnpc),
        .retire_mask   (retire_mask),
        .commit_mask   (commit_mask),
        .commit_num    (commit_num),
        .counted_num   (counted_num),
        .handback      (nonspec_valid),
        .handback_unc  (nonspec_uncached),
        .handback_seq  (nonspec_seq),
        .trap          (trap_req),
        .last_seq      (last_seq),
        .last_npc      (last_npc),
        .last_nnpc     (last_nnpc),
        .store_commit  (store_commit)
    );

    assign map_we = commit_mask & head_dst;

    for (genvar t = 0; t < T; t++) begin : g_thr
        logic mine;
        assign mine = scan_en && (sel_tid == TID_W'(t));
        cc_thread_ctx #(
            .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W), .NUM_W(NUM_W),
            .INST_B(INST_B), .DELAY_SLOT(DELAY_SLOT)
        ) u_ctx (
            .clk           (clk),
            .rst_n         (rst_n),
            .commit_en     (mine && commit_num != '0),
            .remove_en     (mine && retire_mask != '0),
            .counted_num   (counted_num),
            .last_seq      (last_seq),
            .last_npc      (last_npc),
            .last_nnpc     (last_nnpc),
            .trap_fire     (mine && trap_req),
            .trap_clear    (trap_clear[t]),
            .buf_empty     (buf_empty[t]),
            .stores_pending(stores_pending),
            .store_commit  (mine && store_commit),
            .running       (running[t]),
            .trap_pend     (trap_pend[t]),
            .done_seq      (done_seq[t*SEQ_W +: SEQ_W]),
            .pc            (pc_o[t*PC_W +: PC_W]),
            .npc           (npc_o[t*PC_W +: PC_W]),
            .inst_cnt      (inst_cnt[t*CNT_W +: CNT_W]),
            .empty_rpt     (empty_rpt[t])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        bw_cnt <= '0;
        else if (commit_num == NUM_W'(W))  bw_cnt <= bw_cnt + CNT_W'(1);
    end

    logic [W:0] ret_plus;
    assign ret_plus = {1'b0, retire_mask} + {{W{1'b0}}, 1'b1};

    a_r1_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ret_plus));
    a_r1_idle_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (retire_mask == '0 && !nonspec_valid && !trap_req));
    a_r3_handback_serial: assert property (@(posedge clk) disable iff (!rst_n)
        nonspec_valid |-> (!stores_pending && map_we == '0));
    a_r5_single_exception: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nonspec_valid, trap_req}));
    a_r10_map_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (map_we & ~(retire_mask & head_dst)) == '0);

endmodule

// File: tb/tb_commit_ctrl.sv
`timescale 1ns/1ps
module tb_commit_ctrl;
    localparam int W = 4, T = 2, SEQ_W = 16, PC_W = 32, CNT_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic sel_valid, stp;
    logic [0:0] sel_tid;
    logic [T-1:0] bufe, tclr;
    logic [W-1:0] hv, hr, hs, he, hf, hd;
    logic [W*7-1:0] hc;
    logic [W*SEQ_W-1:0] hq;
    logic [W*PC_W-1:0] hn, hnn;
    logic [W-1:0] retire_mask, map_we;
    logic nonspec_valid, nonspec_uncached, trap_req;
    logic [SEQ_W-1:0] nonspec_seq;
    logic [T-1:0] trap_pend, empty_rpt;
    logic [T*SEQ_W-1:0] done_seq;
    logic [T*PC_W-1:0] pc_o, npc_o;
    logic [T*CNT_W-1:0] inst_cnt;
    logic [CNT_W-1:0] bw_cnt;

    commit_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_tid(sel_tid),
        .stores_pending(stp), .buf_empty(bufe), .trap_clear(tclr),
        .head_valid(hv), .head_ready(hr), .head_squashed(hs), .head_executed(he),
        .head_fault(hf), .head_dst(hd), .head_cls(hc), .head_seq(hq),
        .head_npc(hn), .head_nnpc(hnn), .retire_mask(retire_mask), .map_we(map_we),
        .nonspec_valid(nonspec_valid), .nonspec_uncached(nonspec_uncached),
        .nonspec_seq(nonspec_seq), .trap_req(trap_req), .trap_pend(trap_pend),
        .done_seq(done_seq), .pc_o(pc_o), .npc_o(npc_o), .inst_cnt(inst_cnt),
        .bw_cnt(bw_cnt), .empty_rpt(empty_rpt)
    );

    typedef struct {
        logic [W-1:0] ret;
        logic [W-1:0] mwe;
        logic nsv;
        logic nsu;
        logic [SEQ_W-1:0] nss;
        logic trp;
        logic [T-1:0] emp;
        string tag;
    } exp_t;

    exp_t q[$];
    event ev_drv;
    int n_chk = 0, n_err = 0;

    logic [PC_W-1:0] m_pc [T], m_npc [T];
    logic [SEQ_W-1:0] m_done [T];
    logic [CNT_W-1:0] m_cnt [T];
    logic [CNT_W-1:0] m_bw;
    logic m_trap [T], m_arm [T];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        hv = '0; hr = '0; hs = '0; he = '0; hf = '0; hd = '0;
        hc = '0; hq = '0; hn = '0; hnn = '0;
    endtask

    task automatic put(input int i, input bit sq, input bit ex, input bit f,
                       input bit d, input logic [6:0] c, input int seq, input int npc);
        hv[i] = 1'b1; hr[i] = 1'b1; hs[i] = sq; he[i] = ex; hf[i] = f; hd[i] = d;
        hc[i*7 +: 7] = c;
        hq[i*SEQ_W +: SEQ_W] = SEQ_W'(seq);
        hn[i*PC_W +: PC_W] = PC_W'(npc);
        hnn[i*PC_W +: PC_W] = PC_W'(npc + 4);
    endtask

    task automatic check_regs(input string tag);
        for (int t = 0; t < T; t++) begin
            check(pc_o[t*PC_W +: PC_W] == m_pc[t], {tag, " R6 pc"}, pc_o[t*PC_W +: PC_W], m_pc[t]);
            check(npc_o[t*PC_W +: PC_W] == m_npc[t], {tag, " R6 npc"}, npc_o[t*PC_W +: PC_W], m_npc[t]);
            check(done_seq[t*SEQ_W +: SEQ_W] == m_done[t], {tag, " R6 done"}, done_seq[t*SEQ_W +: SEQ_W], m_done[t]);
            check(inst_cnt[t*CNT_W +: CNT_W] == m_cnt[t], {tag, " R7 count"}, inst_cnt[t*CNT_W +: CNT_W], m_cnt[t]);
            check(trap_pend[t] == m_trap[t], {tag, " R5 trap_pend"}, trap_pend[t], m_trap[t]);
        end
        check(bw_cnt == m_bw, {tag, " R8 bw"}, bw_cnt, m_bw);
    endtask

    // reference behaviour derived from the requirements; one cycle
    task automatic step(input string tag);
        exp_t e;
        bit alive, stc;
        int ncom, ncnt;
        logic [SEQ_W-1:0] lseq;
        logic [PC_W-1:0] lnpc;
        e.ret = '0; e.mwe = '0; e.nsv = 0; e.nsu = 0; e.nss = '0; e.trp = 0; e.tag = tag;
        alive = sel_valid && !m_trap[sel_tid];
        ncom = 0; ncnt = 0; stc = 0; lseq = '0; lnpc = '0;
        for (int i = 0; i < W; i++) begin
            logic [6:0] c;
            bit first;
            c = hc[i*7 +: 7];
            if (!alive || !hv[i] || !hr[i]) break;
            if (hs[i]) begin e.ret[i] = 1; continue; end
            first = (ncom == 0) && !stp;
            if (!he[i]) begin
                if (c[0] | c[1] | c[2]) begin
                    if (first) begin e.nsv = 1; e.nss = hq[i*SEQ_W +: SEQ_W]; end
                end else if (c[3]) begin
                    if (first) begin e.nsv = 1; e.nsu = 1; e.nss = hq[i*SEQ_W +: SEQ_W]; end
                end
                break;
            end
            if (hf[i]) begin
                if (first) e.trp = 1;
                break;
            end
            e.ret[i] = 1; e.mwe[i] = hd[i]; ncom++;
            lseq = hq[i*SEQ_W +: SEQ_W]; lnpc = hn[i*PC_W +: PC_W];
            if (!c[5] && !c[6]) ncnt++;
            if (c[4]) stc = 1;
        end
        for (int t = 0; t < T; t++)
            e.emp[t] = m_arm[t] && bufe[t] && !stp && !(stc && sel_tid == t);
        q.push_back(e);
        ->ev_drv;
        @(posedge clk);
        for (int t = 0; t < T; t++) begin
            bit rem;
            rem = (e.ret != '0) && (sel_tid == t);
            m_arm[t] = rem || (m_arm[t] && !e.emp[t]);
            if (m_trap[t] && tclr[t]) m_trap[t] = 0;
        end
        if (e.trp) m_trap[sel_tid] = 1;
        if (ncom > 0) begin
            m_done[sel_tid] = lseq;
            m_pc[sel_tid] = lnpc;
            m_npc[sel_tid] = lnpc + 4;
            m_cnt[sel_tid] = m_cnt[sel_tid] + CNT_W'(ncnt);
        end
        if (ncom == W) m_bw = m_bw + 1;
        @(negedge clk);
        check_regs(tag);
        tclr = '0;
    endtask

    // monitor: compares the same-cycle outputs against queued expectations
    initial begin
        forever begin
            @(ev_drv);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(retire_mask == e.ret, {e.tag, " R1 R2 retire"}, retire_mask, e.ret);
                check(map_we == e.mwe, {e.tag, " R10 map_we"}, map_we, e.mwe);
                check(nonspec_valid == e.nsv, {e.tag, " R3 nonspec_valid"}, nonspec_valid, e.nsv);
                check(nonspec_uncached == e.nsu, {e.tag, " R4 uncached"}, nonspec_uncached, e.nsu);
                if (e.nsv)
                    check(nonspec_seq == e.nss, {e.tag, " R3 nonspec_seq"}, nonspec_seq, e.nss);
                check(trap_req == e.trp, {e.tag, " R5 trap_req"}, trap_req, e.trp);
                check(empty_rpt == e.emp, {e.tag, " R9 empty_rpt"}, empty_rpt, e.emp);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        sel_valid = 1; sel_tid = 0; stp = 0; bufe = '0; tclr = '0;
        clr();
        for (int t = 0; t < T; t++) begin
            m_pc[t] = 0; m_npc[t] = 4; m_done[t] = 0; m_cnt[t] = 0;
            m_trap[t] = 0; m_arm[t] = 1;
        end
        m_bw = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_regs("R11 reset");
        check(retire_mask == '0, "R11 reset retire", retire_mask, 0);

        // R9: empty reporting
        bufe = 2'b11; stp = 1; step("R9 blocked by pending stores");
        stp = 0; step("R9 report after reset");
        step("R9 disarmed after report");
        bufe = 2'b00;

        // R1 R7 R8 R10: full-width commit with a nop
        put(0, 0, 1, 0, 1, 7'h00, 10, 'h100);
        put(1, 0, 1, 0, 1, 7'h20, 11, 'h104);
        put(2, 0, 1, 0, 0, 7'h00, 12, 'h108);
        put(3, 0, 1, 0, 1, 7'h40, 13, 'h10c);
        step("R1 R7 R8 R10 full width");

        // R1: stop at not-ready entry
        clr();
        put(0, 0, 1, 0, 1, 7'h00, 20, 'h200);
        put(1, 0, 1, 0, 0, 7'h00, 21, 'h204);
        put(2, 0, 1, 0, 1, 7'h00, 22, 'h208); hr[2] = 0;
        put(3, 0, 1, 0, 1, 7'h00, 23, 'h20c);
        step("R1 stop at not-ready");

        // R1: no selection
        sel_valid = 0; step("R1 no thread selected"); sel_valid = 1;

        // R2 R3: squashed slot 0 keeps slot 1 first
        clr();
        put(0, 1, 0, 0, 0, 7'h00, 30, 'h300);
        put(1, 0, 0, 0, 0, 7'h01, 31, 'h304);
        step("R2 R3 squashed then handback");

        // R3: serialized entry after a commit waits
        clr();
        put(0, 0, 1, 0, 1, 7'h00, 40, 'h400);
        put(1, 0, 0, 0, 0, 7'h02, 41, 'h404);
        step("R3 not first slot");

        // R3: stores pending blocks barrier
        clr();
        put(0, 0, 0, 0, 0, 7'h04, 42, 'h408);
        stp = 1; step("R3 stores pending"); stp = 0;
        step("R3 barrier handback");

        // R4: uncached load
        clr();
        put(0, 0, 0, 0, 0, 7'h08, 50, 'h500);
        step("R4 uncached load");

        // R2 R8: squashes do not fill the width
        clr();
        put(0, 1, 1, 0, 0, 7'h00, 60, 'h600);
        put(1, 1, 1, 0, 0, 7'h00, 61, 'h604);
        put(2, 0, 1, 0, 1, 7'h00, 62, 'h608);
        put(3, 0, 1, 0, 1, 7'h00, 63, 'h60c);
        step("R2 R8 squashes not counted");

        // R5: fault handling
        clr();
        put(0, 0, 1, 1, 1, 7'h00, 70, 'h700);
        stp = 1; step("R5 fault waits for stores"); stp = 0;
        step("R5 trap raised");
        clr();
        put(0, 0, 1, 0, 1, 7'h00, 71, 'h704);
        step("R5 held while trap pending");

        // R9: store commit on thread 1 suppresses the report
        sel_tid = 1;
        clr();
        put(0, 0, 1, 0, 1, 7'h00, 80, 'h800);
        step("R6 thread1 commit arms report");
        clr();
        put(0, 0, 1, 0, 0, 7'h10, 81, 'h804);
        bufe = 2'b10; step("R9 store commit suppresses report");
        clr();
        step("R9 report after store settles");
        bufe = 2'b00;

        // R5: resume thread 0
        sel_tid = 0;
        clr();
        put(0, 0, 1, 0, 1, 7'h00, 90, 'h900);
        tclr = 2'b01; step("R5 clear cycle still held");
        step("R5 R6 commit after resume");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule